// File: doc/BRIEF.md
# Slave-Port Bus Arbiter

This block decides which of several bus masters owns one slave port of a bus matrix. Each master raises a request line and carries a programmable priority. The arbiter hands the port to one master at a time; that stretch of ownership is called a run. A run lasts until it reaches a boundary, and only at a boundary is the port arbitrated again.

A run ends on any of three events. The first is when the owner drops its request. The second is when the owner has completed its programmed number of data beats. The third is when the owner has held the port for the programmed number of clock cycles. A fairness rule then applies whenever more than one master is contending: the master that held the previous run is passed over, whatever its priority. A fixed build-time access mask removes masters that have no path to this slave. Their requests are neither granted nor counted as contention.

The grant is a registered one-hot vector. Data-path steering and address decoding are done elsewhere in the matrix and use this vector.

Top module: `slave_port_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `gnt` is all zero. `gnt` never has more than one bit set. A grant appears on the clock edge that samples an eligible request while the port is free.
- R2: The parameter `ACCESS_MASK` holds one bit per master, and bit i = 0 means master i cannot reach this slave. The default is 4'b1011, which blocks master 2. A blocked master is never granted, and its request does not count as contention.
- R3: Among the masters that may be granted, the one with the numerically largest priority wins. Master i's priority sits in `prio_flat[i*PRIO_W +: PRIO_W]`.
- R4: When the largest priority is shared, the lowest master index wins.
- R5: When two or more eligible masters request at an arbitration, the master that held the previous run is not granted.
- R6: A master that is the only eligible requester is granted again, back to back, after its own run ends.
- R7: Master i's beat limit is `burst_cap_flat[i*BURST_W +: BURST_W]`. A beat is counted on each cycle with `beat` high. The run ends at the edge where the beat count reaches the limit. A limit of 0 means there is no beat limit.
- R8: A nonzero `slot_cap` ends a run once the owner has held `gnt` for `slot_cap` cycles. When `slot_cap` is 0, there is no cycle limit.
- R9: If the owner drops its request, the run ends at the next edge. If no eligible master is requesting, `gnt` is zero. The previous holder is remembered across idle cycles for R5.
- R10: While a run has not reached a boundary, no other request, whatever its priority, changes `gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N_MST | Request line per master |
| beat | input | 1 | The current owner completes a data beat this cycle |
| prio_flat | input | N_MST*PRIO_W | Packed per-master priority fields |
| burst_cap_flat | input | N_MST*BURST_W | Packed per-master beat limits, 0 = no limit |
| slot_cap | input | SLOT_W | Cycle limit per run, 0 = no limit |
| gnt | output | N_MST | One-hot grant, all zero when the port is idle |

## Verification
The main selection logic is driven with five kinds of request pattern:
- a single requester, which separates a plain grant from a back-to-back regrant;
- overlapping requests during a run, which show that a run is not preempted;
- equal-priority pairs, which expose the tie-break;
- contention that includes the previous holder, which shows the fairness rule overriding priority;
- requests from a blocked master, alone and mixed with others, which show masking and its effect on contention.

The beat limit is exercised with `beat` gaps, so that idle cycles are distinguished from counted beats. It is also run at zero, to show that it is then unlimited. The cycle limit is exercised with two contenders alternating, and with a sole requester that keeps the port.

// File: rtl/arb_pkg.sv
// Shared definitions for the slave-port arbiter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package arb_pkg;

    // Reason the current run stops at this edge (the request-drop case is handled in the top).
    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_BURST = 2'd1,
        END_SLOT  = 2'd2
    } end_cause_e;

    // Default geometry shared by the modules.
    localparam int unsigned DEF_MASTERS = 4;
    localparam int unsigned DEF_PRIO_W  = 2;
    localparam int unsigned DEF_BURST_W = 4;
    localparam int unsigned DEF_SLOT_W  = 8;

endpackage

// File: rtl/arb_prio_pick.sv
// Priority picker: from a candidate mask, chooses the master with the largest
// priority, breaking ties toward the lowest index.
// Assumes: purely combinational; the candidate mask is already filtered by
// access permission and the fairness rule.
module arb_prio_pick #(
    parameter int unsigned N  = arb_pkg::DEF_MASTERS,
    parameter int unsigned PW = arb_pkg::DEF_PRIO_W,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio_flat,
    output logic            pick_vld,
    output logic [IW-1:0]   pick_idx
);

    logic [PW-1:0] prio_a [N];
    logic [PW-1:0] best;

    // Unpack the per-master priority fields.
    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign prio_a[g] = prio_flat[g*PW +: PW];
    end

    // Scan from the top index down; ">=" lets a lower index take an equal priority.
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        best     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i] && (!pick_vld || prio_a[i] >= best)) begin
                pick_vld = 1'b1;
                pick_idx = IW'(i);
                best     = prio_a[i];
            end
        end
    end

endmodule

// File: rtl/arb_run_limit.sv
// Run limiter: counts beats and owned cycles of the current run and reports
// when the beat limit or the cycle limit is reached.
// Assumes: run_start pulses on the edge that installs a new owner; beats are
// single-cycle, so every clock edge is a beat boundary.
module arb_run_limit #(
    parameter int unsigned BW = arb_pkg::DEF_BURST_W,
    parameter int unsigned SW = arb_pkg::DEF_SLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_start,
    input  logic                owner_vld,
    input  logic                beat,
    input  logic [BW-1:0]       burst_cap,
    input  logic [SW-1:0]       slot_cap,
    output arb_pkg::end_cause_e cause
);
    import arb_pkg::*;

    logic [BW-1:0] beat_cnt;
    logic [SW-1:0] cyc_cnt;
    logic [BW:0]   beat_nxt;
    logic [SW:0]   cyc_nxt;

    assign beat_nxt = {1'b0, beat_cnt} + 1'b1;
    assign cyc_nxt  = {1'b0, cyc_cnt} + 1'b1;

    // Count beats and owned cycles; restart on a new run; saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || run_start) begin
            beat_cnt <= '0;
            cyc_cnt  <= '0;
        end else if (owner_vld) begin
            if (beat && !beat_nxt[BW]) beat_cnt <= beat_nxt[BW-1:0];
            if (!cyc_nxt[SW])          cyc_cnt  <= cyc_nxt[SW-1:0];
        end
    end

    // Raise the end cause on the edge where a limit is met; a zero limit is off.
    always_comb begin
        cause = END_NONE;
        if (owner_vld) begin
            if (burst_cap != '0 && beat && beat_nxt >= {1'b0, burst_cap})
                cause = END_BURST;
            else if (slot_cap != '0 && cyc_nxt >= {1'b0, slot_cap})
                cause = END_SLOT;
        end
    end

    // R7: a new run begins with no beats counted.
    a_r7_fresh_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (beat_cnt == '0 && cyc_cnt == '0));

endmodule

// File: rtl/slave_port_arbiter.sv
// Slave-port arbiter top: masks requests by the static access map, applies
// the no-consecutive-run rule under contention, picks by priority, and holds
// the winner until the run ends.
// Assumes: ACCESS_MASK is fixed at build time; gnt is a registered one-hot.
module slave_port_arbiter #(
    parameter int unsigned   N_MST       = arb_pkg::DEF_MASTERS,
    parameter int unsigned   PRIO_W      = arb_pkg::DEF_PRIO_W,
    parameter int unsigned   BURST_W     = arb_pkg::DEF_BURST_W,
    parameter int unsigned   SLOT_W      = arb_pkg::DEF_SLOT_W,
    parameter logic [N_MST-1:0] ACCESS_MASK = 4'b1011
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_MST-1:0]           req,
    input  logic                       beat,
    input  logic [N_MST*PRIO_W-1:0]    prio_flat,
    input  logic [N_MST*BURST_W-1:0]   burst_cap_flat,
    input  logic [SLOT_W-1:0]          slot_cap,
    output logic [N_MST-1:0]           gnt
);
    import arb_pkg::*;

    localparam int unsigned IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

    logic [IDX_W-1:0]   owner_q, last_q, pick_idx;
    logic               owner_vld_q, last_vld_q, pick_vld;
    logic [N_MST-1:0]   elig, cand, last_mask;
    logic [BURST_W-1:0] cur_cap;
    logic               run_end, rearb, run_start, contended;
    end_cause_e         cause;

    assign elig      = req & ACCESS_MASK;
    assign last_mask = N_MST'(1) << last_q;
    assign contended = ($countones(elig) > 1) && last_vld_q;

    // Drop the previous holder from the candidates when others are also waiting.
    always_comb begin
        cand = elig;
        if (contended) cand = elig & ~last_mask;
    end

    arb_prio_pick #(.N(N_MST), .PW(PRIO_W), .IW(IDX_W)) u_pick (
        .cand     (cand),
        .prio_flat(prio_flat),
        .pick_vld (pick_vld),
        .pick_idx (pick_idx)
    );

    assign cur_cap = burst_cap_flat[owner_q*BURST_W +: BURST_W];

    arb_run_limit #(.BW(BURST_W), .SW(SLOT_W)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_start(run_start),
        .owner_vld(owner_vld_q),
        .beat     (beat),
        .burst_cap(cur_cap),
        .slot_cap (slot_cap),
        .cause    (cause)
    );

    assign run_end   = owner_vld_q && (!elig[owner_q] || cause != END_NONE);
    assign rearb     = !owner_vld_q || run_end;
    assign run_start = rearb && pick_vld;

    // Install a new owner at a run boundary and record it as the last holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_vld_q <= 1'b0;
            owner_q     <= '0;
            last_vld_q  <= 1'b0;
            last_q      <= '0;
        end else if (rearb) begin
            owner_vld_q <= pick_vld;
            if (pick_vld) begin
                owner_q    <= pick_idx;
                last_q     <= pick_idx;
                last_vld_q <= 1'b1;
            end
        end
    end

    // Drive the one-hot grant from the owner register.
    assign gnt = owner_vld_q ? (N_MST'(1) << owner_q) : '0;

    // R1: at most one master granted.
    a_r1_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R2: a master outside the access map is never granted.
    a_r2_no_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~ACCESS_MASK) == '0);

    // R5: under contention the previous holder loses the next arbitration.
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb && contended) |=> !gnt[$past(last_q)]);

    // R9: a grant always follows a request seen on the previous edge.
    a_r9_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> ((gnt & $past(elig)) != '0));

    // R9: with no eligible request the port goes idle.
    a_r9_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> (gnt == '0));

    // R10: no change of grant inside a run.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld_q && !run_end) |=> $stable(gnt));

endmodule

// File: tb/tb_slave_port_arbiter.sv
module tb_slave_port_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    // Table entry: {req[3:0], expected gnt[3:0]} after one edge.
    // Priorities m3=1 m2=3 m1=2 m0=2, no limits.
    localparam logic [7:0] VEC [0:12] = '{
        8'h11, 8'h11, 8'h31, 8'h22, 8'h62, 8'h40, 8'h31,
        8'h00, 8'h11, 8'h91, 8'h88, 8'h00, 8'hB1
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         beat = 1'b0;
    logic [N*2-1:0] prio_flat = '0;
    logic [N*4-1:0] burst_flat = '0;
    logic [7:0]   slot_cap = '0;
    logic [N-1:0] gnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    slave_port_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .beat(beat),
        .prio_flat(prio_flat), .burst_cap_flat(burst_flat),
        .slot_cap(slot_cap), .gnt(gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(logic [N-1:0] exp, string tag);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates a pending request.
        req = 4'b0001;
        step(2);
        chk(4'b0000, "R1 in reset");
        rst_n = 1'b1;
        req = '0;
        step();
        chk(4'b0000, "R1 after reset");

        // Table walk: R2 R3 R4 R5 R6 R9 R10.
        prio_flat = {2'd1, 2'd3, 2'd2, 2'd2};
        for (int i = 0; i < 13; i++) begin
            req = VEC[i][7:4];
            step();
            chk(VEC[i][3:0], $sformatf("R5 R10 table step %0d", i));
        end

        // R3: priority decides when the previous holder is not contending.
        req = '0;
        step();
        chk(4'b0000, "R9 idle");
        prio_flat = {2'd3, 2'd3, 2'd2, 2'd2};
        req = 4'b1010;
        step();
        chk(4'b1000, "R3 highest priority");

        // R2: a blocked master that is the only requester gets nothing.
        req = 4'b0100;
        step();
        chk(4'b0000, "R2 blocked sole");

        // R7: beat limit of 3 for master 0, with a gap in the beats.
        burst_flat = 16'h0003;
        req = 4'b0011;
        step();
        chk(4'b0001, "R7 run start");
        beat = 1'b1;
        step();
        chk(4'b0001, "R7 beat 1");
        beat = 1'b0;
        step();
        chk(4'b0001, "R7 gap not counted");
        beat = 1'b1;
        step();
        chk(4'b0001, "R7 beat 2");
        step();
        chk(4'b0010, "R7 limit reached");

        // R7: limit 0 on master 1 is unlimited.
        step(20);
        chk(4'b0010, "R7 zero limit");
        beat = 1'b0;

        // R8: slot limit of 4 cycles alternates two contenders.
        req = '0;
        step();
        burst_flat = '0;
        slot_cap = 8'd4;
        req = 4'b0011;
        step();
        chk(4'b0001, "R8 run start");
        step(3);
        chk(4'b0001, "R8 last owned cycle");
        step();
        chk(4'b0010, "R8 expiry");
        step(3);
        chk(4'b0010, "R8 second run held");
        step();
        chk(4'b0001, "R8 second expiry");

        // R6: a sole requester keeps the port across a slot expiry.
        req = 4'b0001;
        step(6);
        chk(4'b0001, "R6 sole back-to-back");

        // R1: reset in mid-run clears the grant.
        rst_n = 1'b0;
        step();
        chk(4'b0000, "R1 mid-run reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule